// File: doc/BRIEF.md
# Software Reset Pulse Generator

This block lets software pull the system into reset through one configuration register. A write that sets the trigger bit starts a timed low pulse. The pulse drives the bus-reset output and, at the same time, one of two processor-reset outputs. The pulse length is worked out from the clock frequency parameter so that it lands near 1.75 ms. A check at elaboration rejects any clock frequency whose whole-cycle pulse falls outside the 1.5 to 2.0 ms window.

The same register holds two stored control bits. A steering bit chooses which processor output the pulse drives: the hard-reset output or the soft-init output. A delayed-transaction enable bit is kept in the register and is brought out to other logic. The trigger bit is not stored, so it always reads back as 0. A trigger that arrives while a pulse is running starts the timing again, so a pulse is never cut short.

Top module: `swrst_pulse_gen`

## Requirements
- R1: While `rst` is high and on the cycle after it falls, the register reads 00h, `dly_txn_en` is 0, and `bus_rst_n`, `cpu_hard_rst_n` and `cpu_init_n` are all 1.
- R2: A write to `REG_OFFSET` with data bit 0 set drives `bus_rst_n` low from the cycle after the write edge, and keeps it low for exactly PULSE cycles.
- R3: PULSE is floor(CLK_HZ*7/4000), which is 1.75 ms rounded down to whole cycles. Elaboration fails if PULSE lies outside 1.5–2.0 ms.
- R4: Data bit 0 always reads back as 0. A write to `REG_OFFSET` with bit 0 clear starts no pulse.
- R5: Bits 5 down to 1 always read 0, whatever was written to them.
- R6: Bit 7 is read-write. During a pulse, `cpu_hard_rst_n` is low if bit 7 was 0, or `cpu_init_n` is low if bit 7 was 1. Bit 7 is taken as it stands after the triggering write. The other processor output stays high.
- R7: Bit 6 is read-write, and `dly_txn_en` always equals the stored bit 6.
- R8: A trigger written during a pulse restarts it, so `bus_rst_n` stays low for PULSE cycles counted from the later write.
- R9: Writes to any address other than `REG_OFFSET` change nothing, and reads there return 00h.
- R10: Changing bit 7 without a trigger while a pulse is running does not move the running pulse to the other processor output.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, CLK_HZ hertz |
| rst | input | 1 | Synchronous reset, active high |
| cfg_wr | input | 1 | Configuration write strobe |
| cfg_addr | input | ADDR_W | Configuration address |
| cfg_wdata | input | 8 | Configuration write data |
| cfg_rdata | output | 8 | Read data for `cfg_addr`, combinational |
| bus_rst_n | output | 1 | Bus reset, active low |
| cpu_hard_rst_n | output | 1 | Processor hard reset, active low |
| cpu_init_n | output | 1 | Processor soft init, active low |
| dly_txn_en | output | 1 | Stored delayed-transaction enable |

## Verification
The assertions are checked on every cycle. They cover these properties:
- The bus reset and exactly one processor output are low together.
- A trigger reloads the counter to its full value, and the counter then steps down by one each cycle.
- The latched route holds steady while a pulse runs without a retrigger.
- The enable output follows each write.

Some behaviour only the bench scenarios can show. These are the exact pulse length measured in cycles, the restart length after a retrigger, the readback of reserved and trigger bits, and the fact that writes to other addresses or with the trigger clear have no effect at all.

// File: rtl/swrst_pkg.sv
package swrst_pkg;

    localparam int DATA_W    = 8;
    localparam int TRIG_BIT  = 0;
    localparam int DLY_BIT   = 6;
    localparam int STEER_BIT = 7;

    typedef enum logic {
        ROUTE_HARD = 1'b0,
        ROUTE_INIT = 1'b1
    } cpu_route_e;

    typedef struct packed {
        cpu_route_e steer;
        logic       dly_en;
    } ctrl_t;

    // 1.75 ms expressed in clock cycles, rounded down
    function automatic longint unsigned pulse_cycles(longint unsigned clk_hz);
        return (clk_hz * 64'd7) / 64'd4000;
    endfunction

    function automatic logic [DATA_W-1:0] pack_readback(ctrl_t c);
        logic [DATA_W-1:0] v;
        v = '0;
        v[STEER_BIT] = c.steer;
        v[DLY_BIT]   = c.dly_en;
        return v;
    endfunction

endpackage

// File: rtl/swrst_cfg_regs.sv
module swrst_cfg_regs
    import swrst_pkg::*;
#(
    parameter int ADDR_W     = 8,
    parameter int REG_OFFSET = 'h47
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              cfg_wr,
    input  logic [ADDR_W-1:0] cfg_addr,
    input  logic [DATA_W-1:0] cfg_wdata,
    output logic [DATA_W-1:0] cfg_rdata,
    output ctrl_t             ctrl_q,
    output ctrl_t             ctrl_d,
    output logic              trig
);

    logic hit;
    logic wr_hit;
    logic unused_rsvd;

    assign hit         = (cfg_addr == ADDR_W'(REG_OFFSET));
    assign wr_hit      = cfg_wr && hit;
    assign trig        = wr_hit && cfg_wdata[TRIG_BIT];
    assign unused_rsvd = ^cfg_wdata[5:1];

    always_comb begin
        ctrl_d = ctrl_q;
        if (wr_hit) begin
            ctrl_d.steer  = cpu_route_e'(cfg_wdata[STEER_BIT]);
            ctrl_d.dly_en = cfg_wdata[DLY_BIT];
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            ctrl_q <= '{steer: ROUTE_HARD, dly_en: 1'b0};
        end else begin
            ctrl_q <= ctrl_d;
        end
    end

    assign cfg_rdata = hit ? pack_readback(ctrl_q) : '0;

    // R7: a write hit lands in the stored enable on the next cycle
    a_r7_dly_written: assert property (@(posedge clk) disable iff (rst)
        wr_hit |=> ctrl_q.dly_en == $past(cfg_wdata[DLY_BIT]));

    // R9: a cycle with no write hit keeps the stored fields
    a_r9_no_stray_write: assert property (@(posedge clk) disable iff (rst)
        !wr_hit |=> $stable(ctrl_q));

endmodule

// File: rtl/swrst_pulse_timer.sv
module swrst_pulse_timer #(
    parameter int unsigned LIMIT = 16,
    localparam int CNT_W = (LIMIT < 2) ? 1 : $clog2(LIMIT)
) (
    input  logic clk,
    input  logic rst,
    input  logic start,
    output logic active
);

    logic [CNT_W-1:0] cnt;

    always_ff @(posedge clk) begin
        if (rst) begin
            cnt    <= '0;
            active <= 1'b0;
        end else if (start) begin
            cnt    <= CNT_W'(LIMIT - 1);
            active <= 1'b1;
        end else if (active) begin
            if (cnt == '0) begin
                active <= 1'b0;
            end else begin
                cnt <= cnt - 1'b1;
            end
        end
    end

    // R8: every trigger reloads the full count, even mid-pulse
    a_r8_reload_full: assert property (@(posedge clk) disable iff (rst)
        start |=> active && cnt == CNT_W'(LIMIT - 1));

    // R2: a running pulse steps down by exactly one per cycle
    a_r2_count_steps: assert property (@(posedge clk) disable iff (rst)
        (active && !start && cnt != '0) |=> active && cnt == $past(cnt) - 1'b1);

endmodule

// File: rtl/swrst_reset_route.sv
module swrst_reset_route
    import swrst_pkg::*;
(
    input  logic       clk,
    input  logic       rst,
    input  logic       start,
    input  cpu_route_e sel_next,
    input  logic       active,
    output logic       hard_n,
    output logic       init_n
);

    cpu_route_e route_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            route_q <= ROUTE_HARD;
        end else if (start) begin
            route_q <= sel_next;
        end
    end

    assign hard_n = !(active && route_q == ROUTE_HARD);
    assign init_n = !(active && route_q == ROUTE_INIT);

    // R10: the chosen path holds for a pulse unless retriggered
    a_r10_route_held: assert property (@(posedge clk) disable iff (rst)
        (active && !start) |=> $stable(route_q));

    // R6: the route taken is the steering value seen with the trigger
    a_r6_route_from_trigger: assert property (@(posedge clk) disable iff (rst)
        start |=> route_q == $past(sel_next));

endmodule

// File: rtl/swrst_pulse_gen.sv
module swrst_pulse_gen
    import swrst_pkg::*;
#(
    parameter longint unsigned CLK_HZ     = 33_000_000,
    parameter int              ADDR_W     = 8,
    parameter int              REG_OFFSET = 'h47
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              cfg_wr,
    input  logic [ADDR_W-1:0] cfg_addr,
    input  logic [7:0]        cfg_wdata,
    output logic [7:0]        cfg_rdata,
    output logic              bus_rst_n,
    output logic              cpu_hard_rst_n,
    output logic              cpu_init_n,
    output logic              dly_txn_en
);

    localparam longint unsigned PULSE = pulse_cycles(CLK_HZ);

    // R3: elaboration-time window check, 1.5 ms .. 2.0 ms
    if ((PULSE * 64'd2000 < CLK_HZ * 64'd3) || (PULSE * 64'd500 > CLK_HZ)) begin : g_bad_clk
        $error("R3: pulse length outside 1.5-2.0 ms for this CLK_HZ");
    end

    ctrl_t ctrl_q, ctrl_d;
    logic  trig;
    logic  active;

    swrst_cfg_regs #(
        .ADDR_W     (ADDR_W),
        .REG_OFFSET (REG_OFFSET)
    ) u_regs (
        .clk       (clk),
        .rst       (rst),
        .cfg_wr    (cfg_wr),
        .cfg_addr  (cfg_addr),
        .cfg_wdata (cfg_wdata),
        .cfg_rdata (cfg_rdata),
        .ctrl_q    (ctrl_q),
        .ctrl_d    (ctrl_d),
        .trig      (trig)
    );

    swrst_pulse_timer #(
        .LIMIT (int'(PULSE))
    ) u_timer (
        .clk    (clk),
        .rst    (rst),
        .start  (trig),
        .active (active)
    );

    swrst_reset_route u_route (
        .clk      (clk),
        .rst      (rst),
        .start    (trig),
        .sel_next (ctrl_d.steer),
        .active   (active),
        .hard_n   (cpu_hard_rst_n),
        .init_n   (cpu_init_n)
    );

    assign bus_rst_n  = !active;
    assign dly_txn_en = ctrl_q.dly_en;

    // R2/R6: bus reset low means exactly one processor output low
    a_r6_one_cpu_path: assert property (@(posedge clk) disable iff (rst)
        !bus_rst_n |-> $countones({cpu_hard_rst_n, cpu_init_n}) == 1);

    // R2: no processor output moves without the bus reset
    a_r2_cpu_with_bus: assert property (@(posedge clk) disable iff (rst)
        bus_rst_n |-> (cpu_hard_rst_n && cpu_init_n));

    // R1: reset leaves every reset line released
    a_r1_idle_after_reset: assert property (@(posedge clk)
        rst |=> (bus_rst_n && cpu_hard_rst_n && cpu_init_n && !dly_txn_en));

endmodule

// File: tb/swrst_pulse_gen_tb.sv
module swrst_pulse_gen_tb;

    localparam int              CLK_PERIOD = 10;
    localparam longint unsigned TB_CLK_HZ  = 2_000_000;
    localparam int              OFFS       = 'h47;
    localparam int              WATCHDOG   = 150_000;

    logic       clk = 1'b0;
    logic       rst;
    logic       cfg_wr;
    logic [7:0] cfg_addr;
    logic [7:0] cfg_wdata;
    logic [7:0] cfg_rdata;
    logic       bus_rst_n, cpu_hard_rst_n, cpu_init_n, dly_txn_en;

    int n_tests = 0;
    int n_fail  = 0;
    int cycles  = 0;

    logic exp_steer = 1'b0;
    logic exp_dly   = 1'b0;

    always #(CLK_PERIOD/2) clk = ~clk;

    swrst_pulse_gen #(
        .CLK_HZ     (TB_CLK_HZ),
        .ADDR_W     (8),
        .REG_OFFSET (OFFS)
    ) u_dut (
        .clk            (clk),
        .rst            (rst),
        .cfg_wr         (cfg_wr),
        .cfg_addr       (cfg_addr),
        .cfg_wdata      (cfg_wdata),
        .cfg_rdata      (cfg_rdata),
        .bus_rst_n      (bus_rst_n),
        .cpu_hard_rst_n (cpu_hard_rst_n),
        .cpu_init_n     (cpu_init_n),
        .dly_txn_en     (dly_txn_en)
    );

    function automatic int exp_pulse();
        return int'((TB_CLK_HZ * 7) / 4000);
    endfunction

    function automatic logic [7:0] exp_read(input logic [7:0] a);
        return (a == 8'(OFFS)) ? {exp_steer, exp_dly, 6'b0} : 8'h00;
    endfunction

    task automatic check(input logic ok, input string req, input int act, input int exp);
        n_tests++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    task automatic finish_run();
        $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    endtask

    always @(posedge clk) begin
        cycles++;
        if (cycles > WATCHDOG) begin
            n_tests++;
            n_fail++;
            $display("FAIL watchdog actual=%0d expected<%0d", cycles, WATCHDOG);
            finish_run();
        end
    end

    task automatic wr(input logic [7:0] a, input logic [7:0] d);
        @(negedge clk);
        cfg_wr = 1'b1; cfg_addr = a; cfg_wdata = d;
        @(negedge clk);
        cfg_wr = 1'b0;
        if (a == 8'(OFFS)) begin
            exp_steer = d[7];
            exp_dly   = d[6];
        end
    endtask

    task automatic check_read(input logic [7:0] a, input string req);
        cfg_addr = a;
        #1;
        check(cfg_rdata == exp_read(a), req, cfg_rdata, exp_read(a));
        check(dly_txn_en == exp_dly, "R7 dly_txn_en", dly_txn_en, exp_dly);
    endtask

    // Called right after a triggering write; measures the low time
    task automatic measure(input logic steer, input string req);
        int len = 0;
        logic route_ok = 1'b1;
        while (!bus_rst_n && len < 4 * exp_pulse()) begin
            if (steer ? (cpu_init_n || !cpu_hard_rst_n) : (cpu_hard_rst_n || !cpu_init_n))
                route_ok = 1'b0;
            len++;
            @(negedge clk);
        end
        check(len == exp_pulse(), req, len, exp_pulse());
        check(route_ok, "R6 processor path", route_ok, 1);
        check(cpu_hard_rst_n && cpu_init_n, "R2 released after pulse",
              {cpu_hard_rst_n, cpu_init_n}, 3);
    endtask

    initial begin
        void'($urandom(32'h5eed_1234));
        rst = 1'b1; cfg_wr = 1'b0; cfg_addr = '0; cfg_wdata = '0;
        repeat (3) @(negedge clk);
        // R1 during reset
        check(bus_rst_n && cpu_hard_rst_n && cpu_init_n, "R1 lines in reset",
              {bus_rst_n, cpu_hard_rst_n, cpu_init_n}, 7);
        rst = 1'b0;
        @(negedge clk);
        check_read(8'(OFFS), "R1 reset value");
        check(bus_rst_n && cpu_hard_rst_n && cpu_init_n, "R1 lines after reset",
              {bus_rst_n, cpu_hard_rst_n, cpu_init_n}, 7);

        // R4: bit 0 clear, others set -> no pulse; R5 reserved read 0
        wr(8'(OFFS), 8'hFE);
        check(bus_rst_n, "R4 no pulse without trigger", bus_rst_n, 1);
        check_read(8'(OFFS), "R5 reserved bits read 0");
        repeat (5) @(negedge clk);
        check(bus_rst_n, "R4 still no pulse", bus_rst_n, 1);

        // R9: other addresses ignored
        wr(8'h46, 8'hFF);
        check(bus_rst_n, "R9 no pulse from other address", bus_rst_n, 1);
        check_read(8'h46, "R9 other address reads 0");
        check_read(8'(OFFS), "R9 register unchanged");

        // R2/R3/R6: trigger with hard path
        wr(8'(OFFS), 8'h01);
        check_read(8'(OFFS), "R4 trigger reads 0");
        measure(1'b0, "R2 pulse length hard path");

        // R6: trigger with init path, steer from the same write
        wr(8'(OFFS), 8'h81);
        measure(1'b1, "R3 pulse length init path");

        // R10: flip steering mid-pulse without trigger
        wr(8'(OFFS), 8'h81);
        repeat (100) @(negedge clk);
        wr(8'(OFFS), 8'h40);
        check_read(8'(OFFS), "R6 steer readback mid-pulse");
        check(!cpu_init_n && cpu_hard_rst_n, "R10 route held", {cpu_hard_rst_n, cpu_init_n}, 2);
        while (!bus_rst_n) @(negedge clk);

        // R8: retrigger restarts the count
        wr(8'(OFFS), 8'h01);
        repeat (1000) @(negedge clk);
        wr(8'(OFFS), 8'h01);
        measure(1'b0, "R8 retrigger length");

        // Random register traffic, no trigger
        for (int i = 0; i < 60; i++) begin
            logic [7:0] a, d;
            a = ($urandom % 3 == 0) ? 8'($urandom) : 8'(OFFS);
            d = 8'($urandom) & 8'hFE;
            wr(a, d);
            check(bus_rst_n, "R4 random no pulse", bus_rst_n, 1);
            check_read(8'(OFFS), "R7 random readback");
            check_read(a, "R9 random readback");
        end

        // Random triggers with random steering
        for (int i = 0; i < 6; i++) begin
            logic [7:0] d;
            d = 8'($urandom) | 8'h01;
            wr(8'(OFFS), d);
            measure(d[7], "R2 random trigger");
            check_read(8'(OFFS), "R6 random steer readback");
        end

        finish_run();
    end

endmodule